// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block is one DMA channel with a small set of 32-bit control registers and a memory master port. Software loads a source address, a destination address and a unit count. It also loads a command word that selects a per-side increment policy, per-side port widths, a transfer unit size and a completion interrupt enable. It then arms the channel by setting the enable bit in the channel status register. While armed, the engine moves one unit per read/write pair, or per several pairs for multi-byte units. Each finished unit decrements the count.

When the count reaches zero, the channel sets its completion flag. If the interrupt is enabled, it also raises this channel's bit in a global pending register, and that bit drives the `irq` output until software writes it back as zero. A global control register holds the controller enable and the global halt and error flags. Any of these flags, or the channel's own halt or error flag, keeps a unit from starting.

Register byte offsets: source 0x00, destination 0x04, count 0x08, request type 0x0C (a stored 6-bit field with no effect), channel status 0x10, command 0x14, global control 0x20, global pending 0x24.

Top module: `mdma_channel`

## Requirements
- R1: After reset every register reads zero, `mem_req` is low and `irq` is low.
- R2: A count write keeps only its low 24 bits. The count decrements by one per finished unit, never increases without a register write, and reads zero after completion.
- R3: A unit starts only when all of the following hold: global enable (global bit 0), channel enable (status bit 0), non-descriptor mode (status bit 31), a non-zero count, and clear global error (global bit 2), global halt (global bit 3), channel halt (status bit 2) and channel error (status bit 4). Otherwise there is no bus activity.
- R4: For a 32-bit unit (command bits 11:8 = 0), one word is read from the source and written to the destination with strobe 4'hF. An address advances by 4 per unit when its increment bit is set (command bit 23 for source, bit 22 for destination) and stays fixed otherwise.
- R5: Unit codes 1 (8-bit) and 2 (16-bit) move the bytes from the source byte lanes selected by source address bits 1:0 to the destination lanes selected by destination address bits 1:0. The write strobe covers exactly those lanes, and an incrementing address advances by 1 or 2.
- R6: Unit codes 3, 4, 5 and 6 (16, 32, 64 and 128 bytes) run as 4, 8, 16 and 32 read/write word pairs. An incrementing address advances by 4 per pair, and the count drops once per unit.
- R7: When the last unit finishes, status bit 3 is set. If command bit 1 is set, global pending bit CH_IDX is also set and `irq` goes high. Writing that bit as zero clears it, and writing it as one has no effect.
- R8: Port width fields are source bits 15:14 and destination bits 13:12, coded 0 = 32-bit, 1 = 8-bit and 2 = 16-bit. Each address must be aligned to the larger of its port width and the unit size capped at 4 bytes. If it is not, status bit 4 is set, no bus cycle occurs, status bit 3 stays clear and the count is unchanged.
- R9: If the channel is armed while the global halt is set, status bit 2 is set and nothing moves. Once the flags are cleared, the transfer proceeds.
- R10: Clearing the channel enable during a transfer stops the channel at the end of the current unit. The count then holds the number of units not yet moved.
- R11: A memory request keeps its address, direction, data and strobe unchanged until `mem_ready` is high.
- R12: Status bits 2, 3 and 4 are cleared by writing them as zero, and hardware alone sets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_strb | output | 4 | Byte-lane strobe |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | 32 | Read data, valid while a read is accepted |
| irq | output | 1 | This channel's pending interrupt |

## Verification
The bench builds the block with the default 24-bit count and with CH_IDX set to 3. With CH_IDX at 3, a pending bit placed in the wrong lane, or one that ignores its position, shows up on readback. The memory model withholds `mem_ready` one cycle in four, so requests are held across stalls. A behavioural model predicts every beat's address, direction, strobe and data, which reaches the sub-word lane moves, the 128-byte unit with a fixed destination, and an enable cleared part way through a ten-unit run.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} mdma_st_e;

  typedef struct packed {
    logic       src_inc;
    logic       dst_inc;
    logic [1:0] src_pw;
    logic [1:0] dst_pw;
    logic [3:0] usize;
    logic       irq_en;
  } mdma_cmd_t;

  // Unit size code to bytes.
  function automatic logic [7:0] unit_bytes(input logic [3:0] code);
    case (code)
      4'd1:    unit_bytes = 8'd1;
      4'd2:    unit_bytes = 8'd2;
      4'd3:    unit_bytes = 8'd16;
      4'd4:    unit_bytes = 8'd32;
      4'd5:    unit_bytes = 8'd64;
      4'd6:    unit_bytes = 8'd128;
      default: unit_bytes = 8'd4;
    endcase
  endfunction

  // Low-address bits that must be zero for a given port width code.
  function automatic logic [1:0] pw_mask(input logic [1:0] pw);
    case (pw)
      2'd1:    pw_mask = 2'b00;
      2'd2:    pw_mask = 2'b01;
      default: pw_mask = 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/mdma_regs.sv
module mdma_regs
  import mdma_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int CH_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [5:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             adv_src,
  input  logic             adv_dst,
  input  logic [7:0]       step,
  input  logic             dec_cnt,
  input  logic             set_done,
  input  logic             set_aerr,
  input  logic             eng_idle,
  output logic [31:0]      src_addr,
  output logic [31:0]      dst_addr,
  output logic [CNT_W-1:0] cnt,
  output mdma_cmd_t        cmd,
  output logic             go,
  output logic             done_flag,
  output logic             aerr_flag,
  output logic             irq
);

  localparam logic [5:0] A_SRC  = 6'h00;
  localparam logic [5:0] A_DST  = 6'h04;
  localparam logic [5:0] A_CNT  = 6'h08;
  localparam logic [5:0] A_RTY  = 6'h0C;
  localparam logic [5:0] A_STS  = 6'h10;
  localparam logic [5:0] A_CMD  = 6'h14;
  localparam logic [5:0] A_GCTL = 6'h20;
  localparam logic [5:0] A_PEND = 6'h24;

  logic [31:0]      src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [5:0]       rty_q, rty_d;
  mdma_cmd_t        cmd_q, cmd_d;
  logic cen_q, cen_d, chalt_q, chalt_d, cdone_q, cdone_d, caerr_q, caerr_d;
  logic nodesc_q, nodesc_d, gen_q, gen_d, gerr_q, gerr_d, ghalt_q, ghalt_d;
  logic pend_q, pend_d;
  logic armed, hw_halt;

  assign armed   = gen_q & cen_q & nodesc_q & (cnt_q != '0);
  assign go      = armed & ~gerr_q & ~ghalt_q & ~chalt_q & ~caerr_q;
  assign hw_halt = armed & ghalt_q & ~chalt_q & eng_idle;

  always_comb begin
    src_d = src_q;  dst_d = dst_q;  cnt_d = cnt_q;  rty_d = rty_q;  cmd_d = cmd_q;
    cen_d = cen_q;  chalt_d = chalt_q;  cdone_d = cdone_q;  caerr_d = caerr_q;
    nodesc_d = nodesc_q;  gen_d = gen_q;  gerr_d = gerr_q;  ghalt_d = ghalt_q;
    pend_d = pend_q;
    if (reg_we) begin
      case (reg_addr)
        A_SRC:  src_d = reg_wdata;
        A_DST:  dst_d = reg_wdata;
        A_CNT:  cnt_d = reg_wdata[CNT_W-1:0];
        A_RTY:  rty_d = reg_wdata[5:0];
        A_CMD:  cmd_d = '{src_inc: reg_wdata[23], dst_inc: reg_wdata[22],
                          src_pw: reg_wdata[15:14], dst_pw: reg_wdata[13:12],
                          usize: reg_wdata[11:8], irq_en: reg_wdata[1]};
        A_STS: begin
          cen_d    = reg_wdata[0];
          chalt_d  = chalt_q & reg_wdata[2];
          cdone_d  = cdone_q & reg_wdata[3];
          caerr_d  = caerr_q & reg_wdata[4];
          nodesc_d = reg_wdata[31];
        end
        A_GCTL: begin
          gen_d   = reg_wdata[0];
          gerr_d  = reg_wdata[2];
          ghalt_d = reg_wdata[3];
        end
        A_PEND: pend_d = pend_q & reg_wdata[CH_IDX];
        default: ;
      endcase
    end
    if (adv_src)  src_d = src_q + {24'd0, step};
    if (adv_dst)  dst_d = dst_q + {24'd0, step};
    if (dec_cnt)  cnt_d = cnt_q - 1'b1;
    if (set_aerr) caerr_d = 1'b1;
    if (hw_halt)  chalt_d = 1'b1;
    if (set_done) begin
      cdone_d = 1'b1;
      if (cmd_q.irq_en) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;  dst_q <= '0;  cnt_q <= '0;  rty_q <= '0;  cmd_q <= '0;
      cen_q <= 1'b0;  chalt_q <= 1'b0;  cdone_q <= 1'b0;  caerr_q <= 1'b0;
      nodesc_q <= 1'b0;  gen_q <= 1'b0;  gerr_q <= 1'b0;  ghalt_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      src_q <= src_d;  dst_q <= dst_d;  cnt_q <= cnt_d;  rty_q <= rty_d;  cmd_q <= cmd_d;
      cen_q <= cen_d;  chalt_q <= chalt_d;  cdone_q <= cdone_d;  caerr_q <= caerr_d;
      nodesc_q <= nodesc_d;  gen_q <= gen_d;  gerr_q <= gerr_d;  ghalt_q <= ghalt_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SRC: reg_rdata = src_q;
      A_DST: reg_rdata = dst_q;
      A_CNT: reg_rdata[CNT_W-1:0] = cnt_q;
      A_RTY: reg_rdata[5:0] = rty_q;
      A_CMD: begin
        reg_rdata[23]    = cmd_q.src_inc;
        reg_rdata[22]    = cmd_q.dst_inc;
        reg_rdata[15:14] = cmd_q.src_pw;
        reg_rdata[13:12] = cmd_q.dst_pw;
        reg_rdata[11:8]  = cmd_q.usize;
        reg_rdata[1]     = cmd_q.irq_en;
      end
      A_STS: begin
        reg_rdata[31] = nodesc_q;
        reg_rdata[4]  = caerr_q;
        reg_rdata[3]  = cdone_q;
        reg_rdata[2]  = chalt_q;
        reg_rdata[0]  = cen_q;
      end
      A_GCTL: begin
        reg_rdata[3] = ghalt_q;
        reg_rdata[2] = gerr_q;
        reg_rdata[0] = gen_q;
      end
      A_PEND: reg_rdata[CH_IDX] = pend_q;
      default: ;
    endcase
  end

  assign src_addr  = src_q;
  assign dst_addr  = dst_q;
  assign cnt       = cnt_q;
  assign cmd       = cmd_q;
  assign done_flag = cdone_q;
  assign aerr_flag = caerr_q;
  assign irq       = pend_q;

endmodule

// File: rtl/mdma_engine.sv
module mdma_engine
  import mdma_pkg::*;
#(
  parameter int BEAT_W = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        last_unit,
  input  mdma_cmd_t   cmd,
  input  logic [31:0] src_addr,
  input  logic [31:0] dst_addr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_strb,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  output logic        adv_src,
  output logic        adv_dst,
  output logic [7:0]  step,
  output logic        dec_cnt,
  output logic        set_done,
  output logic        set_aerr,
  output logic        idle
);

  mdma_st_e          st_q, st_d;
  logic [BEAT_W-1:0] beat_q, beat_d, beats_m1;
  logic [31:0]       buf_q, buf_d;
  logic [7:0]        bytes;
  logic [1:0]        umask;
  logic              misalign, last_beat;
  logic [3:0]        src_lanes, dst_lanes;

  assign bytes     = unit_bytes(cmd.usize);
  assign step      = (bytes < 8'd4) ? bytes : 8'd4;
  assign beats_m1  = (bytes > 8'd4) ? BEAT_W'(bytes[7:2] - 6'd1) : '0;
  assign last_beat = (beat_q == beats_m1);
  assign umask     = (bytes == 8'd1) ? 2'b00 : (bytes == 8'd2) ? 2'b01 : 2'b11;
  assign misalign  = |(src_addr[1:0] & (pw_mask(cmd.src_pw) | umask)) |
                     |(dst_addr[1:0] & (pw_mask(cmd.dst_pw) | umask));

  // Lane select for sub-word units; whole word otherwise.
  always_comb begin
    case (bytes)
      8'd1: begin
        src_lanes = 4'b0001 << src_addr[1:0];
        dst_lanes = 4'b0001 << dst_addr[1:0];
      end
      8'd2: begin
        src_lanes = 4'b0011 << src_addr[1:0];
        dst_lanes = 4'b0011 << dst_addr[1:0];
      end
      default: begin
        src_lanes = 4'hF;
        dst_lanes = 4'hF;
      end
    endcase
  end

  always_comb begin
    st_d = st_q;  beat_d = beat_q;  buf_d = buf_q;
    adv_src = 1'b0;  adv_dst = 1'b0;  dec_cnt = 1'b0;
    set_done = 1'b0;  set_aerr = 1'b0;
    mem_req = 1'b0;  mem_we = 1'b0;  mem_addr = src_addr;
    mem_wdata = buf_q << {dst_addr[1:0], 3'b000};
    mem_strb = src_lanes;
    case (st_q)
      ST_IDLE: begin
        if (go) begin
          if (misalign) set_aerr = 1'b1;
          else begin
            st_d   = ST_RD;
            beat_d = '0;
          end
        end
      end
      ST_RD: begin
        mem_req = 1'b1;
        if (mem_ready) begin
          buf_d = mem_rdata >> {src_addr[1:0], 3'b000};
          st_d  = ST_WR;
        end
      end
      ST_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_addr;
        mem_strb = dst_lanes;
        if (mem_ready) begin
          adv_src = cmd.src_inc;
          adv_dst = cmd.dst_inc;
          if (last_beat) begin
            dec_cnt  = 1'b1;
            set_done = last_unit;
            beat_d   = '0;
            st_d     = ST_IDLE;
          end else begin
            beat_d = beat_q + 1'b1;
            st_d   = ST_RD;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      buf_q  <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      buf_q  <= buf_d;
    end
  end

  assign idle = (st_q == ST_IDLE);

endmodule

// File: rtl/mdma_channel.sv
module mdma_channel
  import mdma_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int CH_IDX = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_strb,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  output logic        irq
);

  localparam int BEAT_W = 5;

  logic [31:0]      src_addr, dst_addr;
  logic [CNT_W-1:0] cnt;
  mdma_cmd_t        cmd;
  logic [7:0]       step;
  logic go, last_unit, adv_src, adv_dst, dec_cnt, set_done, set_aerr, eng_idle;
  logic done_flag, aerr_flag;

  assign last_unit = (cnt == CNT_W'(1));

  mdma_regs #(.CNT_W(CNT_W), .CH_IDX(CH_IDX)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adv_src(adv_src),
    .adv_dst(adv_dst), .step(step), .dec_cnt(dec_cnt), .set_done(set_done),
    .set_aerr(set_aerr), .eng_idle(eng_idle), .src_addr(src_addr),
    .dst_addr(dst_addr), .cnt(cnt), .cmd(cmd), .go(go),
    .done_flag(done_flag), .aerr_flag(aerr_flag), .irq(irq)
  );

  mdma_engine #(.BEAT_W(BEAT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .last_unit(last_unit), .cmd(cmd),
    .src_addr(src_addr), .dst_addr(dst_addr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_strb(mem_strb), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .adv_src(adv_src), .adv_dst(adv_dst), .step(step), .dec_cnt(dec_cnt),
    .set_done(set_done), .set_aerr(set_aerr), .idle(eng_idle)
  );

endmodule

// File: rtl/mdma_channel_chk.sv
module mdma_channel_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic             mem_req,
  input logic             mem_we,
  input logic [31:0]      mem_addr,
  input logic [31:0]      mem_wdata,
  input logic [3:0]       mem_strb,
  input logic             mem_ready,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             done_flag,
  input logic             aerr_flag
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata) && $stable(mem_strb));

  // R2
  cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> cnt <= $past(cnt));

  // R7
  irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> done_flag);

  // R8
  aerr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aerr_flag) |-> !mem_req && !done_flag);

  // R5
  strb_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> ($countones(mem_strb) == 1) || ($countones(mem_strb) == 2)
                          || (mem_strb == 4'hF));

endmodule

bind mdma_channel mdma_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_strb(mem_strb),
  .mem_ready(mem_ready), .irq(irq), .cnt(cnt), .done_flag(done_flag),
  .aerr_flag(aerr_flag)
);

// File: tb/mdma_channel_bench.sv
`timescale 1ns/1ps
module mdma_channel_bench;

  localparam int CH = 3;
  localparam logic [5:0] SRC = 6'h00, DST = 6'h04, CNT = 6'h08, STS = 6'h10,
                         CMD = 6'h14, GCTL = 6'h20, PEND = 6'h24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_strb;
  logic        mem_ready = 1'b0;

  logic [31:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[11:2]];

  int n_chk = 0, n_fail = 0, hs = 0, cyc = 0;
  logic [31:0] q_addr[$], q_data[$];
  logic        q_we[$];
  logic [3:0]  q_strb[$];

  always #4 clk = ~clk;

  mdma_channel #(.CNT_W(24), .CH_IDX(CH)) u_mdma_channel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_strb(mem_strb), .mem_ready(mem_ready), .mem_rdata(mem_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes_to_bits(input logic [3:0] s);
    logic [31:0] m = '0;
    for (int k = 0; k < 4; k++) if (s[k]) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  // Memory side: throttle ready, compare each accepted beat against the model.
  always @(negedge clk) begin
    cyc++;
    mem_ready = (cyc % 4) != 2;
    if (rst_n && mem_req && mem_ready) begin
      hs++;
      if (q_addr.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R3: actual beat at %0h expected no bus activity", mem_addr);
      end else begin
        logic [31:0] ea, ed, m;
        logic ew;
        logic [3:0] es;
        ea = q_addr.pop_front(); ed = q_data.pop_front();
        ew = q_we.pop_front();   es = q_strb.pop_front();
        check("R11 beat address", mem_addr, ea);
        check("R4 beat direction", {31'd0, mem_we}, {31'd0, ew});
        if (ew) begin
          check("R5 write strobe", {28'd0, mem_strb}, {28'd0, es});
          m = lanes_to_bits(es);
          check("R6 write data", mem_wdata & m, ed & m);
          for (int k = 0; k < 4; k++)
            if (mem_strb[k]) mem[mem_addr[11:2]][8*k +: 8] = mem_wdata[8*k +: 8];
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  function automatic logic [31:0] cmdw(input bit si, input bit di, input int spw,
                                       input int dpw, input int us, input bit ie);
    return (32'(si) << 23) | (32'(di) << 22) | (32'(spw) << 14) |
           (32'(dpw) << 12) | (32'(us) << 8) | (32'(ie) << 1);
  endfunction

  // Behavioural prediction of every beat of a transfer.
  task automatic plan(input logic [31:0] s0, input logic [31:0] d0, input int units,
                      input bit si, input bit di, input int us);
    int by, beats, st;
    logic [31:0] s, d, w;
    case (us)
      1: by = 1;  2: by = 2;  3: by = 16;  4: by = 32;  5: by = 64;  6: by = 128;
      default: by = 4;
    endcase
    beats = (by > 4) ? by / 4 : 1;
    st = (by < 4) ? by : 4;
    s = s0; d = d0;
    for (int u = 0; u < units; u++)
      for (int b = 0; b < beats; b++) begin
        w = mem[s[11:2]];
        q_addr.push_back(s); q_we.push_back(1'b0); q_data.push_back('0); q_strb.push_back('0);
        q_addr.push_back(d); q_we.push_back(1'b1);
        q_data.push_back((w >> (8 * s[1:0])) << (8 * d[1:0]));
        q_strb.push_back(by == 1 ? 4'b0001 << d[1:0] : by == 2 ? 4'b0011 << d[1:0] : 4'hF);
        if (si) s = s + st;
        if (di) d = d + st;
      end
  endtask

  task automatic wait_end();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      rd(STS, v);
      if (v[3] || v[4]) break;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [31:0] v;
    int h0, done_u;
    for (int i = 0; i < 1024; i++)
      mem[i] = {8'(i) + 8'd3, 8'(i) + 8'd2, 8'(i) + 8'd1, 8'(i)} ^ 32'h5A000000;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(STS, v);  check("R1 status", v, 0);
    rd(CNT, v);  check("R1 count", v, 0);
    rd(PEND, v); check("R1 pending", v, 0);
    rd(GCTL, v); check("R1 global", v, 0);
    check("R1 irq/req", {30'd0, irq, mem_req}, 0);

    // R3 global enable off: nothing moves
    wr(CNT, 3); wr(CMD, cmdw(1, 1, 0, 0, 0, 0)); wr(SRC, 32'h100); wr(DST, 32'h200);
    wr(STS, 32'h8000_0001);
    repeat (10) @(negedge clk);
    rd(CNT, v); check("R3 global disabled count", v, 3);
    wr(STS, 32'h0000_0001);
    wr(GCTL, 1);
    repeat (10) @(negedge clk);
    rd(CNT, v); check("R3 descriptor mode count", v, 3);
    wr(STS, 0);

    // R4 R7 32-bit units, both incrementing, interrupt on
    plan(32'h100, 32'h200, 4, 1, 1, 0);
    wr(CNT, 4); wr(CMD, cmdw(1, 1, 0, 0, 0, 1)); wr(STS, 32'h8000_0001);
    wait_end();
    check("R4 beats left", q_addr.size(), 0);
    rd(STS, v);  check("R7 done status", v, 32'h8000_0009);
    rd(CNT, v);  check("R2 count zero", v, 0);
    rd(SRC, v);  check("R4 source advance", v, 32'h110);
    rd(DST, v);  check("R4 dest advance", v, 32'h210);
    rd(PEND, v); check("R7 pending bit", v, 32'h1 << CH);
    check("R7 irq high", {31'd0, irq}, 1);
    wr(PEND, 32'hFFFF_FFFF); rd(PEND, v); check("R7 write one no effect", v, 32'h1 << CH);
    wr(PEND, 0); rd(PEND, v); check("R7 pending cleared", v, 0);
    check("R7 irq low", {31'd0, irq}, 0);
    wr(STS, 32'h8000_0000); rd(STS, v); check("R12 done cleared", v, 32'h8000_0000);

    // R5 8-bit units, fixed destination, no interrupt
    plan(32'h301, 32'h402, 3, 1, 0, 1);
    wr(SRC, 32'h301); wr(DST, 32'h402); wr(CNT, 3);
    wr(CMD, cmdw(1, 0, 1, 1, 1, 0)); wr(STS, 32'h8000_0001);
    wait_end();
    check("R5 byte beats left", q_addr.size(), 0);
    rd(SRC, v);  check("R5 source +1", v, 32'h304);
    rd(DST, v);  check("R5 dest fixed", v, 32'h402);
    rd(PEND, v); check("R7 no irq when disabled", v, 0);
    wr(STS, 32'h8000_0000);

    // R5 16-bit units
    plan(32'h502, 32'h600, 2, 1, 1, 2);
    wr(SRC, 32'h502); wr(DST, 32'h600); wr(CNT, 2);
    wr(CMD, cmdw(1, 1, 2, 2, 2, 0)); wr(STS, 32'h8000_0001);
    wait_end();
    rd(SRC, v); check("R5 source +2", v, 32'h506);
    rd(DST, v); check("R5 dest +2", v, 32'h604);
    wr(STS, 32'h8000_0000);

    // R6 16-byte units
    plan(32'h700, 32'h800, 2, 1, 1, 3);
    wr(SRC, 32'h700); wr(DST, 32'h800); wr(CNT, 2);
    wr(CMD, cmdw(1, 1, 0, 0, 3, 0)); wr(STS, 32'h8000_0001);
    wait_end();
    check("R6 16B beats left", q_addr.size(), 0);
    rd(SRC, v); check("R6 source +32", v, 32'h720);
    wr(STS, 32'h8000_0000);

    // R6 128-byte unit into a fixed destination
    h0 = hs;
    plan(32'hA00, 32'h900, 1, 1, 0, 6);
    wr(SRC, 32'hA00); wr(DST, 32'h900); wr(CNT, 1);
    wr(CMD, cmdw(1, 0, 0, 0, 6, 0)); wr(STS, 32'h8000_0001);
    wait_end();
    check("R6 128B pair count", hs - h0, 64);
    rd(SRC, v); check("R6 source +128", v, 32'hA80);
    rd(DST, v); check("R6 dest fixed", v, 32'h900);
    wr(STS, 32'h8000_0000);

    // R8 misaligned source for a 16-bit port
    wr(SRC, 32'h101); wr(DST, 32'h200); wr(CNT, 5);
    wr(CMD, cmdw(1, 1, 2, 2, 2, 1)); wr(STS, 32'h8000_0001);
    repeat (20) @(negedge clk);
    rd(STS, v); check("R8 error flag, no done", v, 32'h8000_0011);
    rd(CNT, v); check("R8 count kept", v, 5);
    wr(STS, 32'h8000_0000); rd(STS, v); check("R12 error cleared", v, 32'h8000_0000);

    // R9 global halt blocks and flags the channel
    wr(GCTL, 32'h9);
    wr(SRC, 32'h100); wr(DST, 32'h300); wr(CNT, 3);
    wr(CMD, cmdw(1, 1, 0, 0, 0, 0)); wr(STS, 32'h8000_0001);
    repeat (20) @(negedge clk);
    rd(STS, v); check("R9 channel halt set", v, 32'h8000_0005);
    wr(GCTL, 1);
    repeat (10) @(negedge clk);
    rd(CNT, v); check("R9 still halted", v, 3);
    plan(32'h100, 32'h300, 3, 1, 1, 0);
    wr(STS, 32'h8000_0001);
    wait_end();
    rd(CNT, v); check("R9 resumes after clear", v, 0);
    wr(STS, 32'h8000_0000);
    wr(GCTL, 32'h5); wr(CNT, 2); wr(STS, 32'h8000_0001);
    repeat (10) @(negedge clk);
    rd(CNT, v); check("R3 global error blocks", v, 2);
    wr(STS, 0); wr(GCTL, 1);

    // R2 count width limit
    wr(CNT, 32'h0123_4567); rd(CNT, v); check("R2 count masked", v, 32'h0023_4567);

    // R10 enable cleared mid-run
    wr(SRC, 32'h100); wr(DST, 32'h380); wr(CNT, 10);
    wr(CMD, cmdw(1, 1, 0, 0, 0, 1));
    plan(32'h100, 32'h380, 10, 1, 1, 0);
    h0 = hs;
    wr(STS, 32'h8000_0001);
    while (hs - h0 < 5) @(negedge clk);
    wr(STS, 32'h8000_0000);
    repeat (40) @(negedge clk);
    done_u = (hs - h0) / 2;
    check("R10 whole units", (hs - h0) % 2, 0);
    rd(CNT, v); check("R10 remaining count", v, 10 - done_u);
    check("R10 beats not issued", q_addr.size(), (10 - done_u) * 2);
    rd(STS, v); check("R10 no done", v, 32'h8000_0000);
    q_addr.delete(); q_data.delete(); q_we.delete(); q_strb.delete();

    summary();
  end

endmodule